// File: doc/BRIEF.md
# Board Control and Card-Slot Status Registers

This block is a small memory-mapped register file for a development board. A 32-bit bus slave addresses it with a byte address. The word index is the byte address divided by four. The window spans 8 MiB. The block returns a fixed identification word and a fixed decode word. A flash-programming slot always reads as zero.

The block also monitors an SD/MMC card slot through two level inputs, write-protect and card-detect. Both inputs pass through a multi-flop synchronizer before use.

- The write-protect status is a live mirror of the synchronized input.
- A card-detect level sets a sticky card-inserted flag. That flag drives an interrupt line toward a secondary interrupt controller. Software acknowledges it by writing a one to its bit.
- If a set and a software clear meet in the same cycle, the set wins, so an insertion is never lost.

Read data is combinational on the selected address. The optional out-of-window error flag is registered.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at word index 0 returns 0x41034003.
- R2: A read at word index 1 returns zero, and writes to index 1 change no readable register.
- R3: A read at word index 3 returns 0x11, and writes to index 3 change no readable register.
- R4: Bit 0 of the word at index 2 equals the write-protect input, delayed by SYNC_STAGES clock edges. Bits other than 0 and 3 read as zero.
- R5: Bit 3 of the word at index 2 (card-inserted) is set one edge after the synchronized card-detect is high. A later low level on card-detect does not clear it.
- R6: A write to index 2 clears bit 3 only when data bit 3 is one. No written value changes bit 0.
- R7: card_irq is high exactly when bit 3 of the index-2 word is set.
- R8: When card-detect is still high (synchronized) during a clearing write, bit 3 stays set.
- R9: Word indices 4 and above read as zero and ignore writes. With ERR_EN set, bus_err is high for the one cycle after such an access and low otherwise.
- R10: After reset, the index-2 word is zero, card_irq is low and bus_err is low.
- R11: The word index is bus_addr[ADDR_W-1:2]. Address bits 1:0 do not affect the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (23) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, zero when not selected |
| bus_err | output | 1 | One-cycle pulse after an out-of-window access |
| wp_in | input | 1 | Card write-protect level |
| cd_in | input | 1 | Card-detect level |
| card_irq | output | 1 | Card-inserted interrupt request |

## Verification
A wrong sticky flag appears at card_irq within one cycle. It also appears on bit 3 at the next read of index 2, which makes a lost insertion or a failed acknowledge visible on the following access. A wrong synchronizer depth shows as the write-protect bit changing an edge early or late relative to the input. A decode fault shows at once in the combinational read data, or one cycle later in the error flag. The sweep walks every low-nibble write pattern against both write-protect levels and reads all eight low indices.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   localparam logic [31:0] ID_WORD     = 32'h4103_4003;
   localparam logic [31:0] DECODE_WORD = 32'h0000_0011;
   localparam int          WP_POS      = 0;
   localparam int          CARD_POS    = 3;
   localparam int          NUM_REGS    = 4;

   typedef enum logic [1:0] {
      SLOT_ID    = 2'd0,
      SLOT_FLASH = 2'd1,
      SLOT_INT   = 2'd2,
      SLOT_DEC   = 2'd3
   } slot_e;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad
      $error("bcr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= async_in;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bcr_card_state.sv
module bcr_card_state (
   input  logic clk,
   input  logic rst_n,
   input  logic cd_sync,
   input  logic clr_req,
   output logic card_flag
);
   logic flag_q;

   // A set request takes priority over a same-cycle acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (cd_sync) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

   assign card_flag = flag_q;
endmodule

// File: rtl/bcr_rd_mux.sv
module bcr_rd_mux
   import bcr_pkg::*;
(
   input  logic        rd_en,
   input  logic        in_window,
   input  slot_e       slot,
   input  logic [31:0] int_word,
   output logic [31:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en && in_window) begin
         unique case (slot)
            SLOT_ID:    rdata = ID_WORD;
            SLOT_FLASH: rdata = '0;
            SLOT_INT:   rdata = int_word;
            SLOT_DEC:   rdata = DECODE_WORD;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
   import bcr_pkg::*;
#(
   parameter int ADDR_W      = 23,
   parameter int SYNC_STAGES = 2,
   parameter bit ERR_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   input  logic              wp_in,
   input  logic              cd_in,
   output logic              card_irq
);
   localparam int IDX_W  = ADDR_W - 2;
   localparam int SLOT_W = $clog2(NUM_REGS);

   if (ADDR_W < 2 + SLOT_W + 1) begin : g_chk_addr
      $error("board_ctl_regs: ADDR_W too small");
   end

   logic [IDX_W-1:0] word_idx;
   logic             in_window;
   slot_e            slot;
   logic             wp_s, cd_s;
   logic             card_flag;
   logic             clr_req;
   logic [31:0]      int_word;
   logic             unused_bits;

   assign word_idx  = bus_addr[ADDR_W-1:2];
   assign in_window = (word_idx >> SLOT_W) == '0;
   assign slot      = slot_e'(word_idx[SLOT_W-1:0]);
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

   bcr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({cd_in, wp_in}),
      .sync_out ({cd_s, wp_s})
   );

   assign clr_req = bus_sel && bus_wr && in_window && (slot == SLOT_INT)
                    && bus_wdata[CARD_POS];

   bcr_card_state u_card (
      .clk       (clk),
      .rst_n     (rst_n),
      .cd_sync   (cd_s),
      .clr_req   (clr_req),
      .card_flag (card_flag)
   );

   always_comb begin
      int_word           = '0;
      int_word[WP_POS]   = wp_s;
      int_word[CARD_POS] = card_flag;
   end

   bcr_rd_mux u_rd (
      .rd_en     (bus_sel && !bus_wr),
      .in_window (in_window),
      .slot      (slot),
      .int_word  (int_word),
      .rdata     (bus_rdata)
   );

   assign card_irq = card_flag;

   if (ERR_EN) begin : g_err
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= bus_sel && !in_window;
      end
      assign bus_err = err_q;
   end else begin : g_noerr
      assign bus_err = 1'b0;
   end
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
   parameter int ADDR_W = 23,
   parameter bit ERR_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              bus_err,
   input logic              card_irq
);
   logic [ADDR_W-3:0] idx;
   assign idx = bus_addr[ADDR_W-1:2];

   logic rd_now, oow, clr_wr;
   assign rd_now = bus_sel && !bus_wr;
   assign oow    = bus_sel && (idx > 3);
   assign clr_wr = bus_sel && bus_wr && (idx == 2) && bus_wdata[3];

   a_r1_id_const: assert property (@(posedge clk) disable iff (!rst_n)
      rd_now && idx == 0 |-> bus_rdata == 32'h4103_4003);

   a_r3_decode_const: assert property (@(posedge clk) disable iff (!rst_n)
      rd_now && idx == 3 |-> bus_rdata == 32'h11);

   a_r7_irq_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
      rd_now && idx == 2 |-> bus_rdata[3] == card_irq);

   a_r6_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(card_irq) |-> $past(clr_wr));

   a_r9_oow_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_now && idx > 3 |-> bus_rdata == '0);

   a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> ERR_EN && $past(oow));

   a_r9_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
      oow && ERR_EN |=> bus_err);
endmodule

bind board_ctl_regs bcr_checker #(.ADDR_W(ADDR_W), .ERR_EN(ERR_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .card_irq  (card_irq)
);

// File: tb/sim_board_ctl_regs.sv
module sim_board_ctl_regs;
   localparam int AW = 23;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err;
   logic          wp_in = 1'b0, cd_in = 1'b0;
   logic          card_irq;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   board_ctl_regs #(.ADDR_W(AW), .SYNC_STAGES(2), .ERR_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .wp_in(wp_in), .cd_in(cd_in), .card_irq(card_irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One bus access. Read data is sampled just after driving, and the error
   // flag is sampled on the next negedge, after its registering edge.
   task automatic access(string req, bit wr, logic [AW-1:0] addr,
                         logic [31:0] wd, logic [31:0] exp_rd);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      #1;
      if (!wr) check(req, bus_rdata, exp_rd);
      @(negedge clk);
      check({req, " R9 err"}, {31'b0, bus_err},
            {31'b0, (addr[AW-1:2] > 3)});
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] intw(bit card, bit wp);
      return {28'b0, card, 2'b0, wp};
   endfunction

   task automatic set_card();
      @(negedge clk); cd_in = 1'b1;
      idle(1); cd_in = 1'b0;
      idle(4);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R10: state during and after reset
      check("R10 irq", {31'b0, card_irq}, 32'b0);
      check("R10 err", {31'b0, bus_err}, 32'b0);
      rst_n = 1'b1;
      access("R10 int word", 1'b0, 23'd8, '0, 32'h0);

      // R1, R3, R2, R11: sweep the byte offsets within each of the low words
      for (int i = 0; i < 32; i++) begin
         logic [31:0] e;
         case (i / 4)
            0: e = 32'h4103_4003;
            1: e = 32'h0;
            2: e = 32'h0;
            3: e = 32'h11;
            default: e = 32'h0;
         endcase
         access((i/4 == 0) ? "R1/R11" : (i/4 == 1) ? "R2/R11" :
                (i/4 == 3) ? "R3/R11" : (i/4 > 3) ? "R9/R11" : "R11",
                1'b0, AW'(i), '0, e);
      end
      access("R9 top index", 1'b0, {AW{1'b1}}, '0, 32'h0);

      // R4: write-protect mirror and its synchronizer latency
      @(negedge clk); wp_in = 1'b1;
      @(negedge clk); #1 check("R4 early", {31'b0, bus_rdata[0]}, 32'b0);
      bus_sel = 1'b1; bus_addr = 23'd8; #1;
      check("R4 one edge", bus_rdata, intw(0, 0));
      @(negedge clk); #1;
      check("R4 two edges", bus_rdata, intw(0, 1));
      bus_sel = 1'b0;
      @(negedge clk); wp_in = 1'b0; idle(3);
      access("R4 low again", 1'b0, 23'd8, '0, intw(0, 0));

      // R5, R7: set, then hold after the input goes low
      set_card();
      check("R7 irq set", {31'b0, card_irq}, 32'b1);
      access("R5 sticky", 1'b0, 23'd8, '0, intw(1, 0));

      // R2, R3, R9: writes elsewhere leave state and constants untouched
      access("R2 write", 1'b1, 23'd4, 32'hFFFF_FFFF, '0);
      access("R3 write", 1'b1, 23'd12, 32'hFFFF_FFFF, '0);
      access("R9 write", 1'b1, 23'd16, 32'hFFFF_FFFF, '0);
      access("R2 after wr", 1'b0, 23'd4, '0, 32'h0);
      access("R3 after wr", 1'b0, 23'd12, '0, 32'h11);
      access("R9 state kept", 1'b0, 23'd8, '0, intw(1, 0));

      // R6, R7: sweep low-nibble write patterns against both wp levels
      for (int v = 0; v < 32; v++) begin
         @(negedge clk); wp_in = v[4];
         set_card();
         access("R6 write", 1'b1, 23'd8, {28'hFFFFFFF, v[3:0]}, '0);
         access("R6 sweep", 1'b0, 23'd8, '0, intw(!v[3], v[4]));
         check("R7 sweep", {31'b0, card_irq}, {31'b0, !v[3]});
      end

      // R8: clearing write while card-detect is still high keeps the flag
      @(negedge clk); cd_in = 1'b1; idle(4);
      access("R8 set wins", 1'b1, 23'd8, 32'h8, '0);
      access("R8 readback", 1'b0, 23'd8, '0, intw(1, 1));
      check("R8 irq", {31'b0, card_irq}, 32'b1);
      @(negedge clk); cd_in = 1'b0; idle(4);
      access("R6 ack", 1'b1, 23'd8, 32'h8, '0);
      check("R7 irq clear", {31'b0, card_irq}, 32'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule